// File: doc/BRIEF.md
# Rate-Adjustable Time-of-Day Clock

This block is the local time base of a precision-time slave. A time register advances on every clock edge by a per-cycle increment, the timestep. Time and timestep share one fixed-point unit: the upper bits hold whole nanoseconds and the lowest 16 bits hold fractions, so one unit is 2^-16 ns.

The block also trims its own rate. On a measurement strobe, software or a protocol engine presents two lengths of the same elapsed interval: one measured by the master and one measured locally. The block also counts how many local clock cycles passed since the previous accepted strobe. The signed error (master minus slave) is divided by that cycle count, giving the error per cycle. That quotient is added to the timestep. The division is done by a restoring shift-and-subtract divider that produces one quotient bit per cycle. The time register keeps running at the old rate while the divider works, so there is no stall and no lost increment.

Top module: `tod_rate_clock`

## Requirements
- R1: While reset is high the time output is 0 and busy and done are low. Reset loads the timestep from `init_step`, so the first increment after reset equals `init_step`.
- R2: On every clock edge with reset low, the time output increases by the current timestep, zero-extended. This holds during a division as well, with no stall or skipped increment.
- R3: Both intervals are unsigned values in 2^-16 ns units. The error is master minus slave. The correction is the magnitude of the error divided by the cycle count, truncated toward zero, with the sign of the error restored. The new timestep is the old timestep plus the correction, modulo 2^STEP_W.
- R4: When the master and slave intervals are equal, the timestep is unchanged after the update completes, and done still pulses.
- R5: Reset clears the cycle counter. Each edge increments it, saturating at its maximum. An accepted strobe uses the counter's value before that edge as the divisor and sets the counter to 1. The divisor is therefore the number of edges from the previous accepted strobe up to the current one.
- R6: An accepted strobe whose divisor is zero starts no division. Busy and done stay low and the timestep keeps its value.
- R7: An accepted strobe with a nonzero divisor raises busy after its edge, and busy stays high for IVAL_W+1 cycles. Done is high for exactly one cycle: the first cycle in which busy is low again. The new timestep applies from the edge that follows that cycle.
- R8: A strobe that arrives while busy is high is ignored. It changes neither the pending result nor the cycle counter.
- R9: The timestep changes only at the edge that ends a division.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_step | input | STEP_W | Timestep loaded while reset is high |
| meas_stb | input | 1 | Measurement strobe; samples both interval inputs |
| master_ival | input | IVAL_W | Interval length measured by the master |
| slave_ival | input | IVAL_W | Matching interval length measured locally |
| tod | output | TIME_W | Current time, 16 fractional bits |
| busy | output | 1 | Division in progress; strobes are ignored |
| done | output | 1 | One-cycle pulse when the timestep is updated |

## Verification
Directed strobes cover four cases: a strobe in the very first cycle after reset, which gives a zero divisor; a back-to-back strobe, which gives a tiny divisor; equal intervals; and large errors in both directions. Each case separates a distinct path: the division skip, sign restoration, and the plain no-change result. Random strobes with random idle gaps and random signed errors check the quotient across many divisors and exercise the cycle counter's restart. Some of these random strobes carry a second strobe with different values while the divider is busy. Because the following result depends on an unreset divisor, any wrongly accepted strobe shows up later. The time output is checked throughout every division to show that it still advances by the old timestep.

// File: rtl/tod_pkg.sv
package tod_pkg;
  typedef enum logic [1:0] {
    DIV_IDLE = 2'd0,
    DIV_RUN  = 2'd1,
    DIV_FIN  = 2'd2
  } div_state_e;
endpackage

// File: rtl/tod_cycle_count.sv
module tod_cycle_count #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst)                 cnt <= '0;
    else if (restart)        cnt <= CNT_ONE;
    else if (cnt != CNT_MAX) cnt <= cnt + CNT_ONE;
  end
endmodule

// File: rtl/tod_serial_div.sv
module tod_serial_div
  import tod_pkg::*;
#(
  parameter int NUM_W = 40,
  parameter int DEN_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             busy,
  output logic             fin,
  output logic [NUM_W-1:0] quo
);
  localparam int BC_W = (NUM_W > 2) ? $clog2(NUM_W) : 1;
  localparam logic [BC_W-1:0] BC_LAST = BC_W'(NUM_W - 1);

  div_state_e       state;
  logic [DEN_W-1:0] rem_q;
  logic [DEN_W-1:0] den_q;
  logic [NUM_W-1:0] quo_q;
  logic [BC_W-1:0]  bit_cnt;

  logic [DEN_W:0]   trial;
  logic [DEN_W:0]   trial_sub;
  logic             fits;

  // One restoring step: bring down the next dividend bit, try to subtract.
  always_comb begin
    trial     = {rem_q, quo_q[NUM_W-1]};
    trial_sub = trial - {1'b0, den_q};
    fits      = (trial >= {1'b0, den_q});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= DIV_IDLE;
      rem_q   <= '0;
      den_q   <= '0;
      quo_q   <= '0;
      bit_cnt <= '0;
    end else begin
      case (state)
        DIV_IDLE: begin
          if (start) begin
            rem_q   <= '0;
            den_q   <= den;
            quo_q   <= num;
            bit_cnt <= BC_LAST;
            state   <= DIV_RUN;
          end
        end
        DIV_RUN: begin
          rem_q <= fits ? trial_sub[DEN_W-1:0] : trial[DEN_W-1:0];
          quo_q <= {quo_q[NUM_W-2:0], fits};
          if (bit_cnt == '0) state <= DIV_FIN;
          else               bit_cnt <= bit_cnt - 1'b1;
        end
        DIV_FIN: state <= DIV_IDLE;
        default: state <= DIV_IDLE;
      endcase
    end
  end

  assign busy = (state != DIV_IDLE);
  assign fin  = (state == DIV_FIN);
  assign quo  = quo_q;
endmodule

// File: rtl/tod_time_accum.sv
module tod_time_accum #(
  parameter int TIME_W = 64,
  parameter int STEP_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STEP_W-1:0] step,
  output logic [TIME_W-1:0] tod
);
  always_ff @(posedge clk) begin
    if (rst) tod <= '0;
    else     tod <= tod + TIME_W'(step);
  end
endmodule

// File: rtl/tod_rate_clock.sv
module tod_rate_clock #(
  parameter int TIME_W = 64,
  parameter int STEP_W = 32,
  parameter int IVAL_W = 40,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STEP_W-1:0] init_step,
  input  logic              meas_stb,
  input  logic [IVAL_W-1:0] master_ival,
  input  logic [IVAL_W-1:0] slave_ival,
  output logic [TIME_W-1:0] tod,
  output logic              busy,
  output logic              done
);
  logic [CNT_W-1:0]  cnt_q;
  logic              accept;
  logic              div_start;
  logic              div_busy;
  logic              div_fin;
  logic [IVAL_W-1:0] div_quo;

  logic [IVAL_W:0]   err_raw;
  logic              err_neg;
  logic [IVAL_W-1:0] err_mag;
  logic              sign_q;
  logic [STEP_W-1:0] quo_ext;
  logic [STEP_W-1:0] corr;
  logic [STEP_W-1:0] step_q;
  logic              done_q;

  assign accept    = meas_stb && !div_busy;
  assign div_start = accept && (cnt_q != '0);

  // Signed error, split into sign and magnitude for the unsigned divider.
  always_comb begin
    err_raw = {1'b0, master_ival} - {1'b0, slave_ival};
    err_neg = err_raw[IVAL_W];
    err_mag = err_neg ? (~err_raw[IVAL_W-1:0] + 1'b1) : err_raw[IVAL_W-1:0];
  end

  tod_cycle_count #(.CNT_W(CNT_W)) i_cnt (
    .clk     (clk),
    .rst     (rst),
    .restart (accept),
    .cnt     (cnt_q)
  );

  tod_serial_div #(.NUM_W(IVAL_W), .DEN_W(CNT_W)) i_div (
    .clk   (clk),
    .rst   (rst),
    .start (div_start),
    .num   (err_mag),
    .den   (cnt_q),
    .busy  (div_busy),
    .fin   (div_fin),
    .quo   (div_quo)
  );

  always_comb begin
    quo_ext = STEP_W'(div_quo);
    corr    = sign_q ? (~quo_ext + 1'b1) : quo_ext;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sign_q <= 1'b0;
      step_q <= init_step;
      done_q <= 1'b0;
    end else begin
      if (div_start) sign_q <= err_neg;
      if (div_fin)   step_q <= step_q + corr;
      done_q <= div_fin;
    end
  end

  tod_time_accum #(.TIME_W(TIME_W), .STEP_W(STEP_W)) i_acc (
    .clk  (clk),
    .rst  (rst),
    .step (step_q),
    .tod  (tod)
  );

  assign busy = div_busy;
  assign done = done_q;
endmodule

// File: rtl/tod_rate_clock_chk.sv
module tod_rate_clock_chk #(
  parameter int TIME_W = 64,
  parameter int STEP_W = 32,
  parameter int CNT_W  = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              meas_stb,
  input logic              busy,
  input logic              done,
  input logic [TIME_W-1:0] tod,
  input logic [STEP_W-1:0] step_q,
  input logic              div_fin,
  input logic [CNT_W-1:0]  cnt
);
  p_tod_advance_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> tod == $past(tod) + TIME_W'($past(step_q)));

  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_start_busy_r7: assert property (@(posedge clk) disable iff (rst)
    (meas_stb && !busy && cnt != '0) |=> busy);

  p_zero_skip_r6: assert property (@(posedge clk) disable iff (rst)
    (meas_stb && !busy && cnt == '0) |=> !busy);

  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && meas_stb && !div_fin) |=> busy);

  p_cnt_restart_r5: assert property (@(posedge clk) disable iff (rst)
    (meas_stb && !busy) |=> cnt == CNT_W'(1));

  p_step_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !div_fin |=> $stable(step_q));
endmodule

bind tod_rate_clock tod_rate_clock_chk #(
  .TIME_W (TIME_W),
  .STEP_W (STEP_W),
  .CNT_W  (CNT_W)
) i_chk (
  .clk      (clk),
  .rst      (rst),
  .meas_stb (meas_stb),
  .busy     (busy),
  .done     (done),
  .tod      (tod),
  .step_q   (step_q),
  .div_fin  (div_fin),
  .cnt      (cnt_q)
);

// File: tb/test_tod_rate_clock.sv
module test_tod_rate_clock;
  localparam int TIME_W = 64;
  localparam int STEP_W = 32;
  localparam int IVAL_W = 40;
  localparam int CNT_W  = 24;
  localparam logic [31:0] INIT_STEP = 32'h0005_0000;
  localparam int unsigned CNT_MAX = (1 << CNT_W) - 1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [STEP_W-1:0] init_step = INIT_STEP;
  logic              meas_stb = 1'b0;
  logic [IVAL_W-1:0] master_ival = '0;
  logic [IVAL_W-1:0] slave_ival = '0;
  logic [TIME_W-1:0] tod;
  logic              busy;
  logic              done;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] exp_step;
  int unsigned bcnt;

  tod_rate_clock #(
    .TIME_W (TIME_W),
    .STEP_W (STEP_W),
    .IVAL_W (IVAL_W),
    .CNT_W  (CNT_W)
  ) i_tod_rate_clock (
    .clk         (clk),
    .rst         (rst),
    .init_step   (init_step),
    .meas_stb    (meas_stb),
    .master_ival (master_ival),
    .slave_ival  (slave_ival),
    .tod         (tod),
    .busy        (busy),
    .done        (done)
  );

  always #5 clk = ~clk;

  // Expected divisor per R5: edges since the last accepted strobe.
  always @(posedge clk) begin
    if (rst)                   bcnt <= 0;
    else if (meas_stb && !busy) bcnt <= 1;
    else if (bcnt < CNT_MAX)   bcnt <= bcnt + 1;
  end

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] f_next(logic [31:0] old, logic [39:0] m,
                                         logic [39:0] s, int unsigned d);
    logic        neg;
    logic [63:0] mag;
    logic [63:0] q;
    neg = (m < s);
    mag = neg ? (64'(s) - 64'(m)) : (64'(m) - 64'(s));
    q   = mag / 64'(d);
    return neg ? (old - q[31:0]) : (old + q[31:0]);
  endfunction

  // Called at a negedge with busy low.
  task automatic measure(logic [39:0] m, logic [39:0] s, bit poke);
    int unsigned d;
    logic [31:0] nxt;
    logic [63:0] t0;
    logic [63:0] t1;
    string       rq;
    d = bcnt;
    master_ival = m;
    slave_ival  = s;
    meas_stb    = 1'b1;
    @(negedge clk);
    meas_stb = 1'b0;
    if (d == 0) begin
      chk("R6", "busy on zero divisor", 64'(busy), 64'd0);
      t0 = tod;
      @(negedge clk);
      chk("R6", "done on zero divisor", 64'(done), 64'd0);
      t1 = tod;
      chk("R6", "step after zero divisor", t1 - t0, 64'(exp_step));
      return;
    end
    nxt = f_next(exp_step, m, s, d);
    chk("R7", "busy after strobe", 64'(busy), 64'd1);
    t0 = tod;
    for (int i = 1; i <= IVAL_W; i++) begin
      if (poke && (i == 5 || i == IVAL_W)) begin
        meas_stb    = 1'b1;
        master_ival = {$urandom, $urandom};
        slave_ival  = {$urandom, $urandom};
      end
      @(negedge clk);
      meas_stb = 1'b0;
    end
    chk("R7", "busy before end", 64'(busy), 64'd1);
    chk("R7", "done before end", 64'(done), 64'd0);
    t1 = tod;
    chk("R2", "advance during division", t1 - t0, 64'(IVAL_W) * 64'(exp_step));
    @(negedge clk);
    chk("R7", "done at end", 64'(done), 64'd1);
    chk("R7", "busy at end", 64'(busy), 64'd0);
    t0 = tod;
    chk("R9", "old step until update", t0 - t1, 64'(exp_step));
    @(negedge clk);
    t1 = tod;
    chk("R7", "done one cycle", 64'(done), 64'd0);
    rq = (m == s) ? "R4" : (poke ? "R8" : "R3");
    chk(rq, "new step", t1 - t0, 64'(nxt));
    exp_step = nxt;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R7 watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] t0;
    logic [63:0] t1;
    void'($urandom(32'd20240611));
    exp_step = INIT_STEP;
    repeat (4) @(negedge clk);
    chk("R1", "tod in reset", tod, 64'd0);
    chk("R1", "busy in reset", 64'(busy), 64'd0);
    chk("R1", "done in reset", 64'(done), 64'd0);
    rst = 1'b0;
    // Strobe in the first cycle after reset: divisor zero.
    measure(40'd5000, 40'd1000, 1'b0);
    t0 = tod;
    @(negedge clk);
    t1 = tod;
    chk("R1", "first step equals init", t1 - t0, 64'(INIT_STEP));
    // Back-to-back strobe: small divisor.
    measure(40'h12_0000_0003, 40'h12_0000_0000, 1'b0);
    repeat (37) @(negedge clk);
    measure(40'h40_0000_0000, 40'h40_0000_0000, 1'b0);
    repeat (99) @(negedge clk);
    measure(40'h10_0000_0000, 40'h10_0030_0000, 1'b0);
    repeat (63) @(negedge clk);
    measure(40'h20_0007_F000, 40'h20_0000_0000, 1'b0);
    repeat (12) @(negedge clk);
    measure(40'h08_0000_4000, 40'h08_0000_0000, 1'b1);
    for (int k = 0; k < 40; k++) begin
      logic [39:0] m;
      logic [39:0] s;
      int          delta;
      repeat ($urandom_range(0, 300)) @(negedge clk);
      m     = {2'b01, 6'(($urandom)), $urandom};
      delta = int'($urandom_range(0, 32'h0020_0000)) - 32'sh0010_0000;
      if ($urandom_range(0, 7) == 0) delta = 0;
      s = m - 40'(delta);
      measure(m, s, ($urandom_range(0, 3) == 0));
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule